// File: doc/BRIEF.md
# DDR3 Mode-Register-2 Capture and Write-Latency Timer

This block watches the device-side command bus of a DDR3-style memory model. When it sees a mode-register-set command addressed to mode register 2, it checks the address and bank bits and then captures the CAS write latency, the write-time termination choice, the auto self-refresh enable, the extended temperature range bit and the partial-array self-refresh code. It expands the partial-array code into an eight-bit mask that shows which banks keep refreshing in self-refresh. If a request carries a reserved value, the block sets a sticky error flag and keeps its old settings.

The block also times writes. For each write command it raises a one-cycle data-valid strobe exactly WL = AL + CWL clock edges later. AL comes in on a port and CWL comes from the captured field. Any number of writes may be in flight at once. While a write is outstanding, the termination-select output switches to the write-time value, unless write-leveling mode is active. In that mode only the nominal termination can be selected.

Top module: `wlt_mr2_top`

## Requirements
- R1: A mode-register-set command is chip select, RAS, CAS and WE all low at a clock edge. It reaches mode register 2 only when bank bit 1 is 1 and bank bit 0 is 0. A mode-register-set command to any other register leaves every captured field unchanged.
- R2: Address bits [5:3] give the CAS write latency. Codes 000, 001, 010 and 011 set cwlCycles to 5, 6, 7 and 8.
- R3: Address bits [10:9] give the write-time termination: 00 off, 01 RZQ/4, 10 RZQ/2. The code is reported on rttWrSel with the same encoding.
- R4: Address bit 6 drives autoSelfRef (1 = auto self-refresh enabled). Address bit 7 drives extTempSr (1 = extended range).
- R5: Address bits [2:0] set srBankMask, where bit n = 1 means bank n keeps refreshing. The codes map as follows: 000→8'hFF, 001→8'h0F, 010→8'h03, 011→8'h01, 100→8'hFC, 101→8'hF0, 110→8'hC0, 111→8'h80.
- R6: An MR2 request is rejected if any of bank bit 2 or address bits 8, 11, 12 or 13 is 1, if address bit 5 is 1 (reserved latency code), or if address bits [10:9] are 11. A rejected request sets cfgError and leaves every captured field unchanged. cfgError stays at 1 until reset.
- R7: After reset the outputs are: cwlCycles = 5, rttWrSel = 0, autoSelfRef = 0, extTempSr = 0, srBankMask = 8'hFF, cfgError = 0 and wrDataValid = 0.
- R8: A write command is chip select low, RAS high, CAS low and WE low at a clock edge. If it is sampled at edge k, wrDataValid is high for exactly the one cycle that follows edge k + addLat + cwlCycles.
- R9: Writes on consecutive or closely spaced edges each give their own single pulse at their own offset. At least four writes can be outstanding at once.
- R10: termSel encodes 0 = none, 1 = nominal, 2 = write RZQ/4, 3 = write RZQ/2. A write's window runs from the cycle after its command edge through its data-valid cycle. Outside every write window, termSel is 1 when nomTermEn is 1 and 0 otherwise.
- R11: Inside a write window, with rttWrSel nonzero and levelMode low, termSel carries the write-time value (2 or 3). This holds even when nomTermEn is 0.
- R12: While levelMode is high, termSel is never 2 or 3. It follows nomTermEn as it does outside a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bank | input | 3 | Bank address |
| addr | input | 14 | Address bus |
| addLat | input | AL_W (3) | Additive latency in cycles |
| levelMode | input | 1 | Write-leveling mode active |
| nomTermEn | input | 1 | Nominal termination enabled |
| cwlCycles | output | 4 | Captured CAS write latency |
| rttWrSel | output | 2 | Captured write-time termination code |
| autoSelfRef | output | 1 | Auto self-refresh enabled |
| extTempSr | output | 1 | Extended temperature self-refresh |
| srBankMask | output | 8 | Banks kept in self-refresh |
| cfgError | output | 1 | Sticky rejected-request flag |
| wrDataValid | output | 1 | First write data expected this cycle |
| termSel | output | 2 | Termination selection |

## Verification
The assertions assume that reset is applied before the first command. They also assume that two writes never land in the same pipeline slot, which could only happen if the latency shrank while writes were still outstanding. The stimulus changes addLat and the latency field only after every outstanding write has produced its strobe. Overlapping writes in one run all use the same latency. The command pins are always driven to a known value, so each edge decodes as exactly one of no-operation, write or mode-register set.

// File: rtl/wlt_pkg.sv
package wlt_pkg;

  // strobes from command decode to the datapath, at most one per edge
  typedef struct packed {
    logic mrsLoad;
    logic mrsReject;
    logic wrIssue;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    TERM_NONE  = 2'd0,
    TERM_NOM   = 2'd1,
    TERM_WR_Q4 = 2'd2,
    TERM_WR_Q2 = 2'd3
  } termSel_e;

  localparam int MIN_CWL   = 5;
  localparam int MAX_CWL   = 8;
  localparam int NUM_BANKS = 8;

endpackage

// File: rtl/wlt_ctrl.sv
module wlt_ctrl
  import wlt_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        strobe
);

  logic isMrs;
  logic isWrite;
  logic hitMr2;
  logic rsvdBits;
  logic rsvdCode;

  assign isMrs   = !csN && !rasN && !casN && !weN;
  assign isWrite = !csN &&  rasN && !casN && !weN;
  assign hitMr2  = isMrs && bank[1] && !bank[0];

  // reserved-for-future bits that must read zero
  assign rsvdBits = bank[2] || addr[8] || (|addr[13:11]);
  // latency codes 100..111 and termination code 11 are reserved
  assign rsvdCode = addr[5] || (addr[10:9] == 2'b11);

  always_comb begin
    strobe           = '0;
    strobe.wrIssue   = isWrite;
    strobe.mrsLoad   = hitMr2 && !(rsvdBits || rsvdCode);
    strobe.mrsReject = hitMr2 &&  (rsvdBits || rsvdCode);
  end

  // R1: a single edge decodes into at most one action
  a_r1_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.mrsLoad, strobe.mrsReject, strobe.wrIssue}));

  // R1: only an MR2 target may load fields
  a_r1_mr2_only: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mrsLoad |-> (bank[1:0] == 2'b10));

endmodule

// File: rtl/wlt_datapath.sv
module wlt_datapath
  import wlt_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int MAX_AL = 7,
  parameter int AL_W   = $clog2(MAX_AL + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [AL_W-1:0]      addLat,
  input  logic                 levelMode,
  input  logic                 nomTermEn,
  output logic [3:0]           cwlCycles,
  output logic [1:0]           rttWrSel,
  output logic                 autoSelfRef,
  output logic                 extTempSr,
  output logic [NUM_BANKS-1:0] srBankMask,
  output logic                 cfgError,
  output logic                 wrDataValid,
  output logic [1:0]           termSel
);

  localparam int MAX_WL = MAX_AL + MAX_CWL;
  localparam int WL_W   = $clog2(MAX_WL + 1);

  logic [1:0] cwlCode;
  logic [1:0] rttCode;
  logic       asrBit;
  logic       srtBit;
  logic [2:0] pasrCode;
  logic       errSticky;

  // ---------------- field capture ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwlCode   <= 2'd0;
      rttCode   <= 2'd0;
      asrBit    <= 1'b0;
      srtBit    <= 1'b0;
      pasrCode  <= 3'd0;
      errSticky <= 1'b0;
    end else begin
      if (strobe.mrsLoad) begin
        cwlCode  <= addr[4:3];
        rttCode  <= addr[10:9];
        asrBit   <= addr[6];
        srtBit   <= addr[7];
        pasrCode <= addr[2:0];
      end
      if (strobe.mrsReject) begin
        errSticky <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (pasrCode)
      3'b000:  srBankMask = 8'hFF;
      3'b001:  srBankMask = 8'h0F;
      3'b010:  srBankMask = 8'h03;
      3'b011:  srBankMask = 8'h01;
      3'b100:  srBankMask = 8'hFC;
      3'b101:  srBankMask = 8'hF0;
      3'b110:  srBankMask = 8'hC0;
      default: srBankMask = 8'h80;
    endcase
  end

  assign cwlCycles   = 4'(MIN_CWL) + {2'b00, cwlCode};
  assign rttWrSel    = rttCode;
  assign autoSelfRef = asrBit;
  assign extTempSr   = srtBit;
  assign cfgError    = errSticky;

  // ---------------- write-latency pipeline ----------------
  // a write lands in slot WL and walks down one slot per edge;
  // slot 0 is the data-valid cycle
  logic [WL_W-1:0]   wlNow;
  logic [MAX_WL:0]   slotQ;
  logic [MAX_WL:0]   slotD;

  assign wlNow = WL_W'(addLat) + WL_W'(MIN_CWL) + WL_W'(cwlCode);

  for (genvar i = 0; i <= MAX_WL; i++) begin : g_slot
    if (i == MAX_WL) begin : g_head
      assign slotD[i] = strobe.wrIssue && (wlNow == WL_W'(i));
    end else begin : g_body
      assign slotD[i] = slotQ[i+1] || (strobe.wrIssue && (wlNow == WL_W'(i)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) slotQ <= '0;
    else       slotQ <= slotD;
  end

  assign wrDataValid = slotQ[0];

  // ---------------- termination select ----------------
  logic winActive;
  assign winActive = |slotQ;

  always_comb begin
    termSel = nomTermEn ? TERM_NOM : TERM_NONE;
    if (winActive && !levelMode && (rttCode != 2'b00)) begin
      termSel = (rttCode == 2'b01) ? TERM_WR_Q4 : TERM_WR_Q2;
    end
  end

  // R6: a rejected request leaves the captured fields alone
  a_r6_keep_fields: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mrsReject |=> $stable({cwlCode, rttCode, asrBit, srtBit, pasrCode}));

  // R6: the error flag never clears outside reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  // R3: the reserved termination code is never captured
  a_r3_no_rsvd_rtt: assert property (@(posedge clk) disable iff (!rstN)
    rttWrSel != 2'b11);

  // R12: write-leveling keeps dynamic termination away
  a_r12_level_nominal: assert property (@(posedge clk) disable iff (!rstN)
    levelMode |-> (termSel == TERM_NONE || termSel == TERM_NOM));

  // R8: a strobe is always preceded by an occupied pipeline
  a_r8_strobe_has_source: assert property (@(posedge clk) disable iff (!rstN)
    wrDataValid |-> $past(slotQ[1]));

  // R5: some bank always stays in self-refresh
  a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    srBankMask != '0);

endmodule

// File: rtl/wlt_mr2_top.sv
module wlt_mr2_top
  import wlt_pkg::*;
#(
  parameter int MAX_AL = 7,
  localparam int AL_W  = $clog2(MAX_AL + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic [2:0]      bank,
  input  logic [13:0]     addr,
  input  logic [AL_W-1:0] addLat,
  input  logic            levelMode,
  input  logic            nomTermEn,
  output logic [3:0]      cwlCycles,
  output logic [1:0]      rttWrSel,
  output logic            autoSelfRef,
  output logic            extTempSr,
  output logic [7:0]      srBankMask,
  output logic            cfgError,
  output logic            wrDataValid,
  output logic [1:0]      termSel
);

  ctlStrobe_t strobe;

  wlt_ctrl #(
    .ADDR_W(14),
    .BANK_W(3)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .rasN  (rasN),
    .casN  (casN),
    .weN   (weN),
    .bank  (bank),
    .addr  (addr),
    .strobe(strobe)
  );

  wlt_datapath #(
    .ADDR_W(14),
    .MAX_AL(MAX_AL),
    .AL_W  (AL_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addr       (addr),
    .addLat     (addLat),
    .levelMode  (levelMode),
    .nomTermEn  (nomTermEn),
    .cwlCycles  (cwlCycles),
    .rttWrSel   (rttWrSel),
    .autoSelfRef(autoSelfRef),
    .extTempSr  (extTempSr),
    .srBankMask (srBankMask),
    .cfgError   (cfgError),
    .wrDataValid(wrDataValid),
    .termSel    (termSel)
  );

endmodule

// File: tb/wlt_mr2_top_tb_top.sv
`timescale 1ns/1ps
module wlt_mr2_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        csN, rasN, casN, weN;
  logic [2:0]  bank;
  logic [13:0] addr;
  logic [2:0]  addLat;
  logic        levelMode, nomTermEn;
  logic [3:0]  cwlCycles;
  logic [1:0]  rttWrSel;
  logic        autoSelfRef, extTempSr;
  logic [7:0]  srBankMask;
  logic        cfgError, wrDataValid;
  logic [1:0]  termSel;

  int total = 0;
  int bad   = 0;
  int edgeCnt = 0;
  int expQ[$];
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  wlt_mr2_top dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bank(bank), .addr(addr), .addLat(addLat), .levelMode(levelMode),
    .nomTermEn(nomTermEn), .cwlCycles(cwlCycles), .rttWrSel(rttWrSel),
    .autoSelfRef(autoSelfRef), .extTempSr(extTempSr), .srBankMask(srBankMask),
    .cfgError(cfgError), .wrDataValid(wrDataValid), .termSel(termSel)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", tag, act, exp, edgeCnt);
    end
  endtask

  function automatic logic [13:0] mr2Addr(logic [2:0] pasr, logic [2:0] cwl,
                                          logic asr, logic srt, logic [1:0] rtt);
    return {3'b000, rtt, 1'b0, srt, asr, cwl, pasr};
  endfunction

  function automatic int maskFor(int code);
    case (code)
      0: return 'hFF; 1: return 'h0F; 2: return 'h03; 3: return 'h01;
      4: return 'hFC; 5: return 'hF0; 6: return 'hC0; default: return 'h80;
    endcase
  endfunction

  task automatic nop();
    @(negedge clk);
    csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
  endtask

  task automatic mrs(logic [2:0] b, logic [13:0] a);
    @(negedge clk);
    csN = 1'b0; rasN = 1'b0; casN = 1'b0; weN = 1'b0;
    bank = b; addr = a;
  endtask

  // driver: issues a write and predicts its strobe edge
  task automatic wr(int al, int cwl);
    @(negedge clk);
    csN = 1'b0; rasN = 1'b1; casN = 1'b0; weN = 1'b0;
    addLat = 3'(al);
    expQ.push_back(edgeCnt + 1 + al + cwl);
  endtask

  // monitor: pops a prediction for each strobe seen
  always @(negedge clk) begin
    if (rstN && !done && wrDataValid) begin
      if (expQ.size() == 0) begin
        check("R8 unexpected strobe", edgeCnt, -1);
      end else begin
        check("R8 R9 strobe edge", edgeCnt, expQ.pop_front());
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    bank = 3'd0; addr = 14'd0; addLat = 3'd0; levelMode = 1'b0; nomTermEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    nop();

    // R7 reset state
    check("R7 cwl", cwlCycles, 5);
    check("R7 rtt", rttWrSel, 0);
    check("R7 asr", autoSelfRef, 0);
    check("R7 srt", extTempSr, 0);
    check("R7 mask", srBankMask, 'hFF);
    check("R7 err", cfgError, 0);
    check("R7 valid", wrDataValid, 0);
    check("R10 idle term", termSel, 0);

    // R2 R3 R4 R5 capture
    mrs(3'b010, mr2Addr(3'b101, 3'b010, 1'b1, 1'b1, 2'b10));
    nop();
    check("R2 cwl", cwlCycles, 7);
    check("R3 rtt", rttWrSel, 2);
    check("R4 asr", autoSelfRef, 1);
    check("R4 srt", extTempSr, 1);
    check("R5 mask", srBankMask, 'hF0);

    // R1 other registers ignored
    mrs(3'b001, mr2Addr(3'b000, 3'b000, 1'b0, 1'b0, 2'b01));
    nop();
    mrs(3'b011, mr2Addr(3'b011, 3'b001, 1'b0, 1'b0, 2'b00));
    nop();
    check("R1 cwl kept", cwlCycles, 7);
    check("R1 rtt kept", rttWrSel, 2);
    check("R1 mask kept", srBankMask, 'hF0);
    check("R1 asr kept", autoSelfRef, 1);

    // R5 R2 every code
    for (int c = 0; c < 8; c++) begin
      mrs(3'b010, mr2Addr(3'(c), 3'(c % 4), 1'b0, 1'b0, 2'b00));
      nop();
      check("R5 mask code", srBankMask, maskFor(c));
      check("R2 cwl code", cwlCycles, 5 + (c % 4));
    end

    // R6 reserved values rejected; fields stay at pasr 7, cwl 8
    mrs(3'b010, mr2Addr(3'b000, 3'b000, 1'b1, 1'b0, 2'b00) | 14'h0100);
    nop();
    check("R6 err A8", cfgError, 1);
    check("R6 mask kept", srBankMask, 'h80);
    check("R6 cwl kept", cwlCycles, 8);
    check("R6 asr kept", autoSelfRef, 0);
    mrs(3'b010, mr2Addr(3'b000, 3'b100, 1'b0, 1'b0, 2'b00));
    nop();
    check("R6 rsvd cwl kept", cwlCycles, 8);
    mrs(3'b010, mr2Addr(3'b000, 3'b000, 1'b0, 1'b0, 2'b11));
    nop();
    check("R6 rsvd rtt kept", rttWrSel, 0);
    mrs(3'b110, mr2Addr(3'b001, 3'b000, 1'b0, 1'b0, 2'b00));
    nop();
    check("R6 BA2 kept", srBankMask, 'h80);
    mrs(3'b010, mr2Addr(3'b001, 3'b000, 1'b0, 1'b0, 2'b00));
    nop();
    check("R6 err sticky", cfgError, 1);
    check("R6 valid load after", srBankMask, 'h0F);

    // R8 single writes, CWL 5
    wr(0, 5);
    repeat (12) nop();
    wr(3, 5);
    repeat (14) nop();
    // R8 CWL 8 with AL 7
    mrs(3'b010, mr2Addr(3'b000, 3'b011, 1'b0, 1'b0, 2'b00));
    nop();
    wr(7, 8);
    repeat (20) nop();

    // R9 four back-to-back plus spaced writes, same WL
    mrs(3'b010, mr2Addr(3'b000, 3'b001, 1'b0, 1'b0, 2'b00));
    nop();
    for (int i = 0; i < 4; i++) wr(2, 6);
    nop();
    wr(2, 6);
    nop(); nop();
    wr(2, 6);
    repeat (20) nop();
    check("R9 queue drained", expQ.size(), 0);

    // R10 R11 termination window, RZQ/4, CWL 5
    mrs(3'b010, mr2Addr(3'b000, 3'b000, 1'b0, 1'b0, 2'b01));
    nop();
    nomTermEn = 1'b0;
    wr(0, 5);
    nop();
    check("R11 window term", termSel, 2);
    repeat (5) nop();
    check("R11 last window cycle", termSel, 2);
    nop();
    check("R10 after window", termSel, 0);
    nomTermEn = 1'b1;
    nop();
    check("R10 nominal idle", termSel, 1);

    // R11 RZQ/2
    mrs(3'b010, mr2Addr(3'b000, 3'b000, 1'b0, 1'b0, 2'b10));
    nop();
    wr(1, 5);
    nop();
    check("R11 rzq2 term", termSel, 3);
    repeat (10) nop();

    // R12 write leveling
    levelMode = 1'b1;
    wr(0, 5);
    nop();
    check("R12 level nominal", termSel, 1);
    nomTermEn = 1'b0;
    nop();
    check("R12 level none", termSel, 0);
    repeat (10) nop();
    levelMode = 1'b0;
    check("R8 all strobes seen", expQ.size(), 0);

    finishRun();
  end

endmodule